// File: doc/BRIEF.md
# NAND Page Program and Block Erase Sequencer

This block sits between a request source and a lower-level NAND command engine. A single request names either a page to program or a block to erase. The sequencer then walks through the complete chip flow on its own: it describes each command step to the engine, starts it, waits for the engine to finish, and moves to the next step. A program request loads the page data with ECC capture, reloads the spare area with the captured ECC, confirms the program with a ready wait, and reads the status byte. An erase request sends the row address, confirms the erase with a ready wait, and reads the status byte. Each request ends with a one-cycle done pulse carrying a pass or fail flag.

While the page data is streamed, the engine hands over each ECC byte it computes, and the sequencer keeps them. When the spare area is sent, the engine fetches spare bytes by index. The sequencer answers with the caller's spare byte, except that index 0 always reads as 0xFF and the ECC window returns the captured ECC bytes. Write protection is lifted only for the span of an accepted request and put back before the status read. A request with an out-of-range number is refused without any engine activity. An engine error abandons the flow.

Top module: `nand_pgm_seq`

## Requirements
- R1: A program request for page P issues four engine steps in this order. First cmd 0x80 with 5 address bytes, column 0, row P, write, ECC on, and length PAGE_BYTES. Second cmd 0x85 with 2 address bytes, column PAGE_BYTES, write, ECC off, and length SPARE_BYTES. Third cmd 0x10 with 0 address bytes and ready wait. Fourth cmd 0x70 as a read of length 1.
- R2: During any step, an ECC byte offered with ecc_we is stored at slot ecc_idx. sp_rdata for spare index i is 0xFF when i is 0. It is captured slot i-ECC_OFS when ECC_OFS <= i < ECC_OFS+ECC_BYTES (default offset 0x30, 16 slots). Otherwise it is usr_byte.
- R3: An erase request for block B issues cmd 0x60 with 3 address bytes and row B*PAGES_PER_BLK, then cmd 0xD0 with ready wait, then the 0x70 status read.
- R4: After a completed status read, pass is 1 if eng_stat0 (bit 0 of the status byte) is 0, and 0 if it is 1.
- R5: wp is 1 whenever the block is idle. It drops at request acceptance. It is 0 at the start of every step before the status read and 1 at the start of the status read.
- R6: A page number above PAGE_COUNT or a block number above BLOCK_COUNT starts no engine step, leaves wp at 1, and gives done with pass 0 in the cycle after the request. A number equal to the count is accepted.
- R7: If eng_err is 1 with eng_done, no further step starts, wp returns to 1, and the request ends with pass 0 one cycle later.
- R8: eng_start pulses in the cycle after acceptance and in the cycle after each non-final, error-free eng_done. busy is high from acceptance until the done cycle, and is low in the done cycle. done is a single-cycle pulse that comes one cycle after the final eng_done.
- R9: req_valid is ignored while busy or done is high.
- R10: After reset, busy, done, pass and eng_start are 0 and wp is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_erase | input | 1 | 1 = erase block, 0 = program page |
| req_num | input | ROW_W | Page or block number |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| wp | output | 1 | Write protect, 1 = protected |
| eng_start | output | 1 | Start pulse for the engine step |
| eng_cmd | output | 8 | Command code of the step |
| eng_naddr | output | 3 | Number of address bytes |
| eng_col | output | COL_W | Column address |
| eng_row | output | ROW_W | Row address |
| eng_wr | output | 1 | Step writes data to the chip |
| eng_rd | output | 1 | Step reads data from the chip |
| eng_ecc | output | 1 | ECC capture on for the step |
| eng_wait | output | 1 | Wait for chip ready after the command |
| eng_len | output | LEN_W | Data byte count |
| eng_done | input | 1 | Engine finished the step |
| eng_err | input | 1 | Engine error, valid with eng_done |
| eng_stat0 | input | 1 | Bit 0 of the status byte, valid with eng_done |
| ecc_we | input | 1 | Engine offers an ECC byte |
| ecc_idx | input | ECC_AW | ECC slot index |
| ecc_byte | input | 8 | ECC byte value |
| sp_idx | input | SP_AW | Spare byte index fetched by the engine |
| usr_byte | input | 8 | Caller's spare byte for sp_idx |
| sp_rdata | output | 8 | Spare byte sent to the chip |

## Verification
The first eng_start is due in the cycle after acceptance. Each later eng_start is due in the cycle after the engine's eng_done. done follows the final eng_done, or a refused request, by exactly one cycle. The bench drives inputs and samples outputs at the falling edge, so each of these checks falls on the first falling edge after the clock edge that should produce the change. Step descriptors and write-protect levels are compared at every eng_start against a queue filled by the request driver. Spare bytes are combinational, so they are compared a fraction of a cycle after each index change.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_DIN, ST_RND, ST_PCNF, ST_ESET, ST_ECNF, ST_STAT, ST_FIN
   } seq_st_t;

   localparam logic [7:0] OP_DATA_IN  = 8'h80;
   localparam logic [7:0] OP_RAND_IN  = 8'h85;
   localparam logic [7:0] OP_PROG     = 8'h10;
   localparam logic [7:0] OP_ERS_SET  = 8'h60;
   localparam logic [7:0] OP_ERS_GO   = 8'hD0;
   localparam logic [7:0] OP_STATUS   = 8'h70;
   localparam logic [7:0] OP_RESET    = 8'hFF;
endpackage

// File: rtl/nand_seq_range.sv
module nand_seq_range #(
   parameter int NUM_W       = 24,
   parameter int PAGE_LIMIT  = 65536,
   parameter int BLOCK_LIMIT = 1024
) (
   input  logic             erase,
   input  logic [NUM_W-1:0] num,
   output logic             ok
);
   localparam logic [NUM_W:0] PG_MAX = (NUM_W+1)'(PAGE_LIMIT);
   localparam logic [NUM_W:0] BK_MAX = (NUM_W+1)'(BLOCK_LIMIT);

   if (NUM_W < 2 || NUM_W > 31) begin : g_bad_w
      $error("nand_seq_range: NUM_W out of range");
   end

   assign ok = erase ? ({1'b0, num} <= BK_MAX) : ({1'b0, num} <= PG_MAX);
endmodule

// File: rtl/nand_seq_desc.sv
module nand_seq_desc
   import nand_seq_pkg::*;
#(
   parameter int COL_W       = 16,
   parameter int ROW_W       = 24,
   parameter int LEN_W       = 12,
   parameter int PAGE_BYTES  = 2048,
   parameter int SPARE_BYTES = 64,
   parameter int PPB_LOG2    = 6
) (
   input  seq_st_t          st,
   input  logic [ROW_W-1:0] num,
   output logic [7:0]       cmd,
   output logic [2:0]       naddr,
   output logic [COL_W-1:0] col,
   output logic [ROW_W-1:0] row,
   output logic             wr,
   output logic             rd,
   output logic             ecc,
   output logic             wt,
   output logic [LEN_W-1:0] len
);
   if (PAGE_BYTES >= (1 << LEN_W) + 1 || PAGE_BYTES >= (1 << COL_W)) begin : g_bad_len
      $error("nand_seq_desc: field too narrow for page size");
   end

   always_comb begin
      cmd = '0; naddr = '0; col = '0; row = '0;
      wr = 1'b0; rd = 1'b0; ecc = 1'b0; wt = 1'b0; len = '0;
      case (st)
         ST_DIN: begin
            cmd = OP_DATA_IN; naddr = 3'd5; row = num;
            wr = 1'b1; ecc = 1'b1; len = LEN_W'(PAGE_BYTES);
         end
         ST_RND: begin
            cmd = OP_RAND_IN; naddr = 3'd2; col = COL_W'(PAGE_BYTES);
            wr = 1'b1; len = LEN_W'(SPARE_BYTES);
         end
         ST_PCNF: begin
            cmd = OP_PROG; wt = 1'b1;
         end
         ST_ESET: begin
            cmd = OP_ERS_SET; naddr = 3'd3; row = num << PPB_LOG2;
         end
         ST_ECNF: begin
            cmd = OP_ERS_GO; wt = 1'b1;
         end
         ST_STAT: begin
            cmd = OP_STATUS; rd = 1'b1; len = LEN_W'(1);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/nand_seq_spare.sv
module nand_seq_spare #(
   parameter int SP_AW     = 6,
   parameter int ECC_BYTES = 16,
   parameter int ECC_OFS   = 48,
   parameter int ECC_AW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_we,
   input  logic [ECC_AW-1:0] ecc_idx,
   input  logic [7:0]        ecc_byte,
   input  logic [SP_AW-1:0]  sp_idx,
   input  logic [7:0]        usr_byte,
   output logic [7:0]        sp_rdata
);
   localparam int WIN_END = ECC_OFS + ECC_BYTES;

   if (ECC_OFS < 1 || WIN_END > (1 << SP_AW) || ECC_BYTES > (1 << ECC_AW)) begin : g_bad_map
      $error("nand_seq_spare: ECC window does not fit the spare area");
   end

   logic [7:0] slot [ECC_BYTES];

   for (genvar k = 0; k < ECC_BYTES; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   slot[k] <= 8'h00;
         else if (ecc_we && ecc_idx == ECC_AW'(k))     slot[k] <= ecc_byte;
      end
   end

   logic [SP_AW:0]  rel;
   logic            in_win;
   assign rel    = {1'b0, sp_idx} - (SP_AW+1)'(ECC_OFS);
   assign in_win = ({1'b0, sp_idx} >= (SP_AW+1)'(ECC_OFS)) &&
                   ({1'b0, sp_idx} <  (SP_AW+1)'(WIN_END));

   always_comb begin
      sp_rdata = usr_byte;
      if (sp_idx == '0) sp_rdata = 8'hFF;
      else begin
         for (int k = 0; k < ECC_BYTES; k++)
            if (in_win && rel == (SP_AW+1)'(k)) sp_rdata = slot[k];
      end
   end
endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq
   import nand_seq_pkg::*;
#(
   parameter int PAGE_BYTES    = 2048,
   parameter int SPARE_BYTES   = 64,
   parameter int PAGES_PER_BLK = 64,
   parameter int PAGE_COUNT    = 65536,
   parameter int BLOCK_COUNT   = 1024,
   parameter int ECC_BYTES     = 16,
   parameter int ECC_OFS       = 48,
   parameter int ROW_W         = 24,
   parameter int COL_W         = 16,
   localparam int LEN_W        = $clog2(PAGE_BYTES + 1),
   localparam int SP_AW        = $clog2(SPARE_BYTES),
   localparam int ECC_AW       = $clog2(ECC_BYTES),
   localparam int PPB_LOG2     = $clog2(PAGES_PER_BLK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_erase,
   input  logic [ROW_W-1:0]  req_num,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              wp,
   output logic              eng_start,
   output logic [7:0]        eng_cmd,
   output logic [2:0]        eng_naddr,
   output logic [COL_W-1:0]  eng_col,
   output logic [ROW_W-1:0]  eng_row,
   output logic              eng_wr,
   output logic              eng_rd,
   output logic              eng_ecc,
   output logic              eng_wait,
   output logic [LEN_W-1:0]  eng_len,
   input  logic              eng_done,
   input  logic              eng_err,
   input  logic              eng_stat0,
   input  logic              ecc_we,
   input  logic [ECC_AW-1:0] ecc_idx,
   input  logic [7:0]        ecc_byte,
   input  logic [SP_AW-1:0]  sp_idx,
   input  logic [7:0]        usr_byte,
   output logic [7:0]        sp_rdata
);
   if ((1 << PPB_LOG2) != PAGES_PER_BLK) begin : g_bad_ppb
      $error("nand_pgm_seq: PAGES_PER_BLK must be a power of two");
   end

   seq_st_t          st;
   logic             ph;
   logic             pass_q;
   logic [ROW_W-1:0] num_q;
   logic             num_ok;

   nand_seq_range #(.NUM_W(ROW_W), .PAGE_LIMIT(PAGE_COUNT), .BLOCK_LIMIT(BLOCK_COUNT))
      u_range (.erase(req_erase), .num(req_num), .ok(num_ok));

   nand_seq_desc #(.COL_W(COL_W), .ROW_W(ROW_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
                   .SPARE_BYTES(SPARE_BYTES), .PPB_LOG2(PPB_LOG2))
      u_desc (.st(st), .num(num_q), .cmd(eng_cmd), .naddr(eng_naddr), .col(eng_col),
              .row(eng_row), .wr(eng_wr), .rd(eng_rd), .ecc(eng_ecc), .wt(eng_wait),
              .len(eng_len));

   nand_seq_spare #(.SP_AW(SP_AW), .ECC_BYTES(ECC_BYTES), .ECC_OFS(ECC_OFS), .ECC_AW(ECC_AW))
      u_spare (.clk(clk), .rst_n(rst_n), .ecc_we(ecc_we), .ecc_idx(ecc_idx),
               .ecc_byte(ecc_byte), .sp_idx(sp_idx), .usr_byte(usr_byte), .sp_rdata(sp_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; ph <= 1'b0; wp <= 1'b1; pass_q <= 1'b0; num_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               num_q  <= req_num;
               ph     <= 1'b0;
               pass_q <= 1'b0;
               if (num_ok) begin
                  wp <= 1'b0;
                  st <= req_erase ? ST_ESET : ST_DIN;
               end else begin
                  st <= ST_FIN;
               end
            end
            ST_FIN: st <= ST_IDLE;
            default: begin
               if (!ph) ph <= 1'b1;
               else if (eng_done) begin
                  ph <= 1'b0;
                  if (eng_err) begin
                     st <= ST_FIN; wp <= 1'b1; pass_q <= 1'b0;
                  end else begin
                     case (st)
                        ST_DIN:  st <= ST_RND;
                        ST_RND:  st <= ST_PCNF;
                        ST_PCNF: begin st <= ST_STAT; wp <= 1'b1; end
                        ST_ESET: st <= ST_ECNF;
                        ST_ECNF: begin st <= ST_STAT; wp <= 1'b1; end
                        default: begin st <= ST_FIN; pass_q <= ~eng_stat0; end
                     endcase
                  end
               end
            end
         endcase
      end
   end

   assign eng_start = (st != ST_IDLE) && (st != ST_FIN) && !ph;
   assign busy      = (st != ST_IDLE) && (st != ST_FIN);
   assign done      = (st == ST_FIN);
   assign pass      = done && pass_q;
endmodule

// File: rtl/nand_pgm_seq_chk.sv
module nand_pgm_seq_chk #(
   parameter int NUM_W       = 24,
   parameter int PAGE_LIMIT  = 65536,
   parameter int BLOCK_LIMIT = 1024
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_erase,
   input logic [NUM_W-1:0] req_num,
   input logic             busy,
   input logic             done,
   input logic             pass,
   input logic             wp,
   input logic             eng_start,
   input logic [7:0]       eng_cmd
);
   logic out_of_range;
   assign out_of_range = req_erase ? ({1'b0, req_num} > (NUM_W+1)'(BLOCK_LIMIT))
                                   : ({1'b0, req_num} > (NUM_W+1)'(PAGE_LIMIT));

   p_idle_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> wp);
   p_stat_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && eng_cmd == 8'h70) |-> wp);
   p_open_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && eng_cmd != 8'h70) |-> !wp);
   p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !done && out_of_range) |=> (done && !pass && !eng_start));
   p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy);
   p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy) && !$past(done)) |-> $past(req_valid));
endmodule

bind nand_pgm_seq nand_pgm_seq_chk #(.NUM_W(ROW_W), .PAGE_LIMIT(PAGE_COUNT), .BLOCK_LIMIT(BLOCK_COUNT))
   u_chk (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
          .req_num(req_num), .busy(busy), .done(done), .pass(pass), .wp(wp),
          .eng_start(eng_start), .eng_cmd(eng_cmd));

// File: tb/nand_pgm_seq_bench.sv
module nand_pgm_seq_bench;
   localparam int PG_CNT = 65536;
   localparam int BK_CNT = 1024;

   typedef struct packed {
      logic [7:0]  cmd;
      logic [2:0]  na;
      logic [15:0] col;
      logic [23:0] row;
      logic        wr, rd, ecc, wt;
      logic [11:0] len;
      logic        wpv;
   } desc_t;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_erase = 0;
   logic [23:0] req_num = '0;
   logic busy, done, pass, wp, eng_start;
   logic [7:0] eng_cmd;
   logic [2:0] eng_naddr;
   logic [15:0] eng_col;
   logic [23:0] eng_row;
   logic eng_wr, eng_rd, eng_ecc, eng_wait;
   logic [11:0] eng_len;
   logic eng_done = 0, eng_err = 0, eng_stat0 = 0, ecc_we = 0;
   logic [3:0] ecc_idx = '0;
   logic [7:0] ecc_byte = '0, usr_byte = '0;
   logic [5:0] sp_idx = '0;
   logic [7:0] sp_rdata;

   int checks = 0, fails = 0;
   desc_t exp_q[$];
   logic  res_q[$];
   logic [7:0] ecc_seed = 8'h00, inj_cmd = 8'h00;
   logic       stat_bit = 1'b0;

   always #5 clk = ~clk;

   nand_pgm_seq u_nand_pgm_seq (.*);

   function automatic logic [7:0] ecc_val(int k);
      return ecc_seed + 8'(k * 29);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   task automatic push(logic [7:0] c, logic [2:0] n, logic [15:0] co, logic [23:0] r,
                       logic w, logic rr, logic e, logic t, logic [11:0] l, logic p);
      desc_t d;
      d = '{c, n, co, r, w, rr, e, t, l, p};
      exp_q.push_back(d);
   endtask

   // engine model and descriptor scoreboard
   task automatic serve();
      desc_t got, exp;
      int bad;
      got = '{eng_cmd, eng_naddr, eng_col, eng_row, eng_wr, eng_rd, eng_ecc, eng_wait, eng_len, wp};
      if (exp_q.size() == 0) chk(0, "R1/R3/R7", "unexpected step", int'(got.cmd), 0);
      else begin
         exp = exp_q.pop_front();
         chk(got == exp, "R1/R3/R5", "step descriptor", int'(got[63:0]), int'(exp[63:0]));
      end
      if (got.cmd == 8'h80) begin
         for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            ecc_we = 1; ecc_idx = 4'(k); ecc_byte = ecc_val(k);
         end
         @(negedge clk);
         ecc_we = 0;
      end
      if (got.cmd == 8'h85) begin
         bad = 0;
         for (int i = 0; i < 64; i++) begin
            logic [7:0] e;
            sp_idx = 6'(i); usr_byte = 8'(i) ^ 8'h5A;
            #1;
            e = (i == 0) ? 8'hFF : (i >= 48) ? ecc_val(i - 48) : (8'(i) ^ 8'h5A);
            if (sp_rdata != e) begin
               bad++;
               $display("FAIL R2 spare byte %0d actual=%0h expected=%0h", i, sp_rdata, e);
            end
         end
         checks++;
         if (bad != 0) fails++;
      end
      repeat (3) @(negedge clk);
      eng_err = (got.cmd == inj_cmd);
      eng_stat0 = (got.cmd == 8'h70) ? stat_bit : 1'b0;
      eng_done = 1;
      @(negedge clk);
      eng_done = 0; eng_err = 0; eng_stat0 = 0;
      if (exp_q.size() > 0) chk(eng_start == 1, "R8", "start after engine done", eng_start, 1);
      else chk(done == 1, "R8", "done after final step", done, 1);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         while (eng_start) serve();
      end
   end

   // result monitor
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            logic e;
            chk(busy == 0, "R8", "busy low in done cycle", busy, 0);
            chk(wp == 1, "R5/R7", "wp restored at done", wp, 1);
            if (res_q.size() == 0) chk(0, "R9", "unexpected result", pass, 0);
            else begin
               e = res_q.pop_front();
               chk(pass == e, "R4/R6/R7", "pass flag", pass, e);
            end
         end
      end
   end

   task automatic run_req(logic er, int num, logic sb, logic [7:0] ic, bit junk);
      bit ok;
      logic ex;
      while (busy || done) @(negedge clk);
      ok = er ? (num <= BK_CNT) : (num <= PG_CNT);
      ecc_seed = ecc_seed + 8'h3B; stat_bit = sb; inj_cmd = ic;
      if (ok) begin
         if (!er) begin
            push(8'h80, 5, 0, 24'(num), 1, 0, 1, 0, 12'd2048, 0);
            if (ic != 8'h80) push(8'h85, 2, 16'd2048, 0, 1, 0, 0, 0, 12'd64, 0);
            if (ic != 8'h80 && ic != 8'h85) push(8'h10, 0, 0, 0, 0, 0, 0, 1, 0, 0);
            if (ic == 8'h00) push(8'h70, 0, 0, 0, 0, 1, 0, 0, 12'd1, 1);
         end else begin
            push(8'h60, 3, 0, 24'(num * 64), 0, 0, 0, 0, 0, 0);
            if (ic != 8'h60) push(8'hD0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
            if (ic == 8'h00) push(8'h70, 0, 0, 0, 0, 1, 0, 0, 12'd1, 1);
         end
      end
      ex = ok && (ic == 8'h00) && !sb;
      res_q.push_back(ex);
      req_valid = 1; req_erase = er; req_num = 24'(num);
      @(negedge clk);
      req_valid = 0;
      if (ok) begin
         chk(eng_start == 1, "R8", "start one cycle after accept", eng_start, 1);
         chk(busy == 1, "R8", "busy after accept", busy, 1);
      end else begin
         chk(done == 1 && eng_start == 0, "R6", "refused in one cycle", {done, eng_start}, 2);
         chk(wp == 1, "R6", "wp untouched on refusal", wp, 1);
      end
      if (junk) begin
         req_valid = 1; req_erase = ~er; req_num = 24'd7;
      end
      while (!done) @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      chk(exp_q.size() == 0, "R1/R3/R7", "remaining expected steps", exp_q.size(), 0);
      if (junk) begin
         repeat (3) @(negedge clk);
         chk(busy == 0 && eng_start == 0, "R9", "request during busy ignored", busy, 0);
      end
   endtask

   initial begin
      #2000000;
      chk(0, "ALL", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && pass == 0 && eng_start == 0, "R10", "reset outputs",
          {busy, done, pass, eng_start}, 0);
      chk(wp == 1, "R10", "reset wp", wp, 1);
      rst_n = 1;
      @(negedge clk);
      run_req(0, 5, 0, 8'h00, 0);          // R1 R2 R4 program pass
      run_req(0, 300, 1, 8'h00, 0);        // R4 program fail
      run_req(1, 3, 0, 8'h00, 0);          // R3 erase pass
      run_req(1, 17, 1, 8'h00, 0);         // R3 R4 erase fail
      run_req(0, PG_CNT, 0, 8'h00, 0);     // R6 boundary page accepted
      run_req(1, BK_CNT, 0, 8'h00, 0);     // R6 boundary block accepted
      run_req(0, PG_CNT + 1, 0, 8'h00, 0); // R6 page refused
      run_req(1, BK_CNT + 1, 0, 8'h00, 0); // R6 block refused
      run_req(0, 42, 0, 8'h85, 0);         // R7 abort on spare step
      run_req(1, 9, 0, 8'hD0, 0);          // R7 abort on erase confirm
      run_req(0, 77, 0, 8'h00, 1);         // R9 request held while busy
      finish_run();
   end
endmodule